// File: doc/BRIEF.md
# Guarded Three-Source Integer Adder

This unit takes one 128-bit instruction word per strobe and executes a three-source 32-bit integer addition in a single registered step. The unit reads the three source operands from an external 256-entry register file and reads its guard and carry-in bits from an external 8-entry one-bit predicate file. It reports the resulting register write and predicate writes as registered write-back strobes. The surrounding file storage applies them. Each source may be negated. A mode bit changes that negation into a bitwise complement and also enables two selectable carry-in predicates.

The block drives the three source indices combinationally from the instruction word and expects the matching register data on the same cycle. The predicate file is presented as a flat 8-bit vector. One cycle after a strobe, the unit presents a register write (enable, index, data), a per-predicate write mask with values, and a one-cycle illegal flag. These outputs are zero in every cycle that follows no strobe.

Top module: `tri_add_exec`

## Requirements
- R1: The opcode is the 13-bit value {insn[91], insn[11:0]}. When a strobed word's opcode differs from 13'h210, `illegal` is high for exactly the next cycle, and that cycle shows no register write and no predicate write.
- R2: The guard predicate index is insn[14:12] and insn[15] inverts it. If the resulting guard is false, the strobed instruction produces no register write and no predicate write.
- R3: Predicate index 7 always reads as 1 and index 0 always reads as 0, whatever `pred_file` holds. A carry-out aimed at index 0 or 7 never raises its `pred_we` bit.
- R4: The source indices are A = insn[31:24], B = insn[39:32], C = insn[71:64], and the destination is insn[23:16]. Register index 255 reads as zero, and a result aimed at 255 raises no `wb_en`.
- R5: With insn[74] clear, a set modifier flag (insn[72] for A, insn[63] for B, insn[75] for C) replaces that operand with its two's-complement negation, and both carry-ins are zero.
- R6: With insn[74] set, a set modifier flag replaces the operand with its bitwise complement. Two carry-ins are added: the first is the predicate at insn[89:87] XOR insn[90], and the second is the predicate at insn[79:77] XOR insn[80].
- R7: The first carry-out is the carry out of bit 31 of A'+B'+cin0+cin1, written to the predicate at insn[83:81]. The second carry-out is the carry out of adding C' to the low 32 bits of that partial sum, written to the predicate at insn[86:84]. When both indices are equal, the second value wins.
- R8: A strobe's results appear on the outputs in the cycle after the clock edge that samples it, for one cycle only. All outputs are zero after reset and in cycles that follow no strobe.
- R9: `wb_data` is the low 32 bits of A'+B'+C'+cin0+cin1, and `wb_idx` is the destination index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction strobe |
| insn | input | 128 | Instruction word |
| src_a_idx | output | 8 | Register-file read index for source A |
| src_b_idx | output | 8 | Register-file read index for source B |
| src_c_idx | output | 8 | Register-file read index for source C |
| src_a_data | input | 32 | Register data for source A |
| src_b_data | input | 32 | Register data for source B |
| src_c_data | input | 32 | Register data for source C |
| pred_file | input | 8 | Current predicate file contents |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 8 | Register write index |
| wb_data | output | 32 | Register write data (sum) |
| pred_we | output | 8 | Predicate write mask |
| pred_wval | output | 8 | Predicate write values |
| illegal | output | 1 | Unrecognised opcode seen |

## Verification
The addition is exercised with several kinds of operands. Values near 0 and 0xFFFFFFFF make each carry-out fire on its own, which shows which stage produces which carry. A modified operand of 5 in each mode separates negation (0xFFFFFFFB) from complement (0xFFFFFFFA). A set of fixed vectors and a run of random words are compared against a reference model that updates its own copy of the files, so predicates written earlier later act as guards and carry-ins. Directed words then test the false guards, register 255, the two constant predicates read with and without inversion, equal carry-out indices, and both opcode halves being wrong.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
    localparam int XLEN    = 32;
    localparam int IW      = 128;
    localparam int RIDX_W  = 8;
    localparam int PIDX_W  = 3;
    localparam int NPRED   = 1 << PIDX_W;
    localparam int OPC_W   = 13;
    localparam logic [OPC_W-1:0]  OPC_ADD3  = 13'h210;
    localparam logic [RIDX_W-1:0] REG_ZERO  = '1;
    localparam logic [PIDX_W-1:0] PRED_TRUE = '1;
    localparam logic [PIDX_W-1:0] PRED_FALSE = '0;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [PIDX_W-1:0] guard;
        logic              guard_inv;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] rc;
        logic              mod_a;
        logic              mod_b;
        logic              mod_c;
        logic              ext;
        logic [PIDX_W-1:0] cin0_idx;
        logic              cin0_inv;
        logic [PIDX_W-1:0] cin1_idx;
        logic              cin1_inv;
        logic [PIDX_W-1:0] co0_idx;
        logic [PIDX_W-1:0] co1_idx;
    } fields_t;

    typedef struct packed {
        logic              wb_en;
        logic [RIDX_W-1:0] wb_idx;
        logic [XLEN-1:0]   wb_data;
        logic [NPRED-1:0]  pwe;
        logic [NPRED-1:0]  pval;
        logic              illegal;
    } wb_state_t;

    function automatic logic pred_read(input logic [NPRED-1:0] pf,
                                       input logic [PIDX_W-1:0] idx);
        if (idx == PRED_TRUE)       return 1'b1;
        else if (idx == PRED_FALSE) return 1'b0;
        else                        return pf[idx];
    endfunction

    function automatic logic pred_writable(input logic [PIDX_W-1:0] idx);
        return (idx != PRED_TRUE) && (idx != PRED_FALSE);
    endfunction
endpackage

// File: rtl/tri_add_decode.sv
module tri_add_decode
    import tri_add_pkg::*;
(
    input  logic [IW-1:0] insn,
    output fields_t       f
);
    logic unused_bits;

    always_comb begin
        f.opc       = {insn[91], insn[11:0]};
        f.guard     = insn[14:12];
        f.guard_inv = insn[15];
        f.rd        = insn[23:16];
        f.ra        = insn[31:24];
        f.rb        = insn[39:32];
        f.rc        = insn[71:64];
        f.mod_a     = insn[72];
        f.mod_b     = insn[63];
        f.mod_c     = insn[75];
        f.ext       = insn[74];
        f.cin0_idx  = insn[89:87];
        f.cin0_inv  = insn[90];
        f.cin1_idx  = insn[79:77];
        f.cin1_inv  = insn[80];
        f.co0_idx   = insn[83:81];
        f.co1_idx   = insn[86:84];
    end

    assign unused_bits = ^{insn[127:92], insn[76], insn[73], insn[62:40]};
endmodule

// File: rtl/tri_add_opmod.sv
module tri_add_opmod #(
    parameter int W      = 32,
    parameter int IDX_W  = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     raw,
    input  logic             flag,
    input  logic             ext,
    output logic [W-1:0]     val
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '1;
    logic [W-1:0] src;

    always_comb begin
        src = (idx == ZERO_IDX) ? '0 : raw;
        if (!flag)    val = src;
        else if (ext) val = ~src;
        else          val = (~src) + W'(1);
    end
endmodule

// File: rtl/tri_add_core.sv
module tri_add_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         cin0,
    input  logic         cin1,
    output logic [W-1:0] sum,
    output logic         co0,
    output logic         co1
);
    logic [W+1:0] part_d;
    logic [W:0]   full_d;

    always_comb begin
        part_d = {2'b00, a} + {2'b00, b} + {{(W+1){1'b0}}, cin0} + {{(W+1){1'b0}}, cin1};
        full_d = {1'b0, part_d[W-1:0]} + {1'b0, c};
        sum    = full_d[W-1:0];
        co0    = |part_d[W+1:W];
        co1    = full_d[W];
    end
endmodule

// File: rtl/tri_add_exec.sv
module tri_add_exec
    import tri_add_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_valid,
    input  logic [IW-1:0]        insn,
    output logic [RIDX_W-1:0]    src_a_idx,
    output logic [RIDX_W-1:0]    src_b_idx,
    output logic [RIDX_W-1:0]    src_c_idx,
    input  logic [XLEN-1:0]      src_a_data,
    input  logic [XLEN-1:0]      src_b_data,
    input  logic [XLEN-1:0]      src_c_data,
    input  logic [NPRED-1:0]     pred_file,
    output logic                 wb_en,
    output logic [RIDX_W-1:0]    wb_idx,
    output logic [XLEN-1:0]      wb_data,
    output logic [NPRED-1:0]     pred_we,
    output logic [NPRED-1:0]     pred_wval,
    output logic                 illegal
);
    localparam int NSRC = 3;

    fields_t         f;
    wb_state_t       st_d, st_q;
    logic            legal_d, guard_ok_d, cin0_d, cin1_d;
    logic            co0_d, co1_d;
    logic [XLEN-1:0] sum_d;

    logic [RIDX_W-1:0] idx_arr   [NSRC];
    logic [XLEN-1:0]   raw_arr   [NSRC];
    logic              flag_arr  [NSRC];
    logic [XLEN-1:0]   opnd_arr  [NSRC];

    tri_add_decode u_dec (.insn(insn), .f(f));

    assign idx_arr[0]  = f.ra;    assign raw_arr[0] = src_a_data; assign flag_arr[0] = f.mod_a;
    assign idx_arr[1]  = f.rb;    assign raw_arr[1] = src_b_data; assign flag_arr[1] = f.mod_b;
    assign idx_arr[2]  = f.rc;    assign raw_arr[2] = src_c_data; assign flag_arr[2] = f.mod_c;

    generate
        for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
            tri_add_opmod #(.W(XLEN), .IDX_W(RIDX_W)) u_mod (
                .idx  (idx_arr[gi]),
                .raw  (raw_arr[gi]),
                .flag (flag_arr[gi]),
                .ext  (f.ext),
                .val  (opnd_arr[gi])
            );
        end
    endgenerate

    assign cin0_d = f.ext & (pred_read(pred_file, f.cin0_idx) ^ f.cin0_inv);
    assign cin1_d = f.ext & (pred_read(pred_file, f.cin1_idx) ^ f.cin1_inv);

    tri_add_core #(.W(XLEN)) u_core (
        .a    (opnd_arr[0]),
        .b    (opnd_arr[1]),
        .c    (opnd_arr[2]),
        .cin0 (cin0_d),
        .cin1 (cin1_d),
        .sum  (sum_d),
        .co0  (co0_d),
        .co1  (co1_d)
    );

    assign legal_d    = (f.opc == OPC_ADD3);
    assign guard_ok_d = pred_read(pred_file, f.guard) ^ f.guard_inv;

    always_comb begin
        st_d = '0;
        if (insn_valid) begin
            if (!legal_d) begin
                st_d.illegal = 1'b1;
            end else if (guard_ok_d) begin
                st_d.wb_en   = (f.rd != REG_ZERO);
                st_d.wb_idx  = f.rd;
                st_d.wb_data = sum_d;
                if (pred_writable(f.co0_idx)) begin
                    st_d.pwe[f.co0_idx]  = 1'b1;
                    st_d.pval[f.co0_idx] = co0_d;
                end
                if (pred_writable(f.co1_idx)) begin
                    st_d.pwe[f.co1_idx]  = 1'b1;
                    st_d.pval[f.co1_idx] = co1_d;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_a_idx = f.ra;
    assign src_b_idx = f.rb;
    assign src_c_idx = f.rc;
    assign wb_en     = st_q.wb_en;
    assign wb_idx    = st_q.wb_idx;
    assign wb_data   = st_q.wb_data;
    assign pred_we   = st_q.pwe;
    assign pred_wval = st_q.pval;
    assign illegal   = st_q.illegal;

    // R1: bad opcode gives a flag and no writes on the next cycle
    a_r1_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && !legal_d |=> illegal && !wb_en && (pred_we == '0));

    // R2: a false guard blocks every write
    a_r2_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && legal_d && !guard_ok_d |=> !wb_en && (pred_we == '0) && !illegal);

    // R3: carry-outs aimed only at constant predicates write nothing
    a_r3_const_pred: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && !pred_writable(f.co0_idx) && !pred_writable(f.co1_idx) |=> pred_we == '0);

    // R4: destination 255 never raises a register write
    a_r4_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && (f.rd == REG_ZERO) |=> !wb_en);

    // R8: no strobe, no activity on the next cycle
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !wb_en && (pred_we == '0) && !illegal);

    // R8: an executed instruction writes back the sampled destination
    a_r8_exec: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && legal_d && guard_ok_d && (f.rd != REG_ZERO)
        |=> wb_en && (wb_idx == $past(f.rd)));
endmodule

// File: tb/sim_tri_add_exec.sv
`timescale 1ns/1ps
module sim_tri_add_exec;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         insn_valid = 1'b0;
    logic [127:0] insn = '0;
    logic [7:0]   a_idx, b_idx, c_idx;
    logic [31:0]  a_data, b_data, c_data;
    logic [7:0]   pm = '0;
    logic         wb_en, illegal;
    logic [7:0]   wb_idx, pred_we, pred_wval;
    logic [31:0]  wb_data;

    logic [31:0]  regs [256];
    int           checks = 0;
    int           errors = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    assign a_data = regs[a_idx];
    assign b_data = regs[b_idx];
    assign c_data = regs[c_idx];

    tri_add_exec u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .src_a_idx(a_idx), .src_b_idx(b_idx), .src_c_idx(c_idx),
        .src_a_data(a_data), .src_b_data(b_data), .src_c_data(c_data),
        .pred_file(pm), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .pred_we(pred_we), .pred_wval(pred_wval), .illegal(illegal)
    );

    typedef struct packed {
        logic       ext, ma, mb, mc;
        logic [7:0] ra, rb, rc, rd;
        logic [2:0] pu, pv, pp;
        logic       ppn;
        logic [2:0] pq;
        logic       pqn;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VT [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0, 8'd10, 8'd11, 8'd12, 8'd20, 3'd1, 3'd2, 3'd7, 1'b0, 3'd7, 1'b0},
        '{1'b0,1'b1,1'b0,1'b0, 8'd13, 8'd14, 8'd15, 8'd21, 3'd3, 3'd4, 3'd7, 1'b0, 3'd7, 1'b0},
        '{1'b0,1'b0,1'b1,1'b1, 8'd16, 8'd17, 8'd18, 8'd22, 3'd5, 3'd6, 3'd0, 1'b0, 3'd0, 1'b0},
        '{1'b1,1'b0,1'b0,1'b0, 8'd3,  8'd4,  8'd3,  8'd23, 3'd1, 3'd2, 3'd7, 1'b0, 3'd7, 1'b0},
        '{1'b1,1'b1,1'b1,1'b0, 8'd19, 8'd20, 8'd21, 8'd24, 3'd3, 3'd4, 3'd1, 1'b0, 3'd2, 1'b1},
        '{1'b1,1'b0,1'b1,1'b1, 8'd30, 8'd31, 8'd32, 8'd25, 3'd5, 3'd6, 3'd5, 1'b1, 3'd6, 1'b0},
        '{1'b0,1'b1,1'b1,1'b1, 8'd33, 8'd34, 8'd35, 8'd26, 3'd2, 3'd3, 3'd7, 1'b0, 3'd7, 1'b0},
        '{1'b1,1'b1,1'b1,1'b1, 8'd36, 8'd37, 8'd38, 8'd27, 3'd4, 3'd5, 3'd0, 1'b1, 3'd7, 1'b1}
    };

    function automatic logic [127:0] mk(input logic ext, ma, mb, mc,
                                        input logic [7:0] ra, rb, rc, rd,
                                        input logic [2:0] pu, pv, pp, input logic ppn,
                                        input logic [2:0] pq, input logic pqn,
                                        input logic [2:0] g, input logic gn);
        logic [127:0] w = '0;
        w[11:0]  = 12'h210;
        w[14:12] = g;   w[15] = gn;
        w[23:16] = rd;  w[31:24] = ra; w[39:32] = rb; w[71:64] = rc;
        w[72] = ma; w[63] = mb; w[75] = mc; w[74] = ext;
        w[89:87] = pp;  w[90] = ppn;
        w[79:77] = pq;  w[80] = pqn;
        w[83:81] = pu;  w[86:84] = pv;
        return w;
    endfunction

    function automatic logic prd(input logic [2:0] i);
        if (i == 3'd7) return 1'b1;
        if (i == 3'd0) return 1'b0;
        return pm[i];
    endfunction

    function automatic logic [31:0] rr(input logic [7:0] i);
        return (i == 8'd255) ? 32'd0 : regs[i];
    endfunction

    function automatic logic [31:0] md(input logic [31:0] v, input logic f, input logic x);
        if (!f) return v;
        if (x)  return ~v;
        return 32'd0 - v;
    endfunction

    logic        e_en, e_ill;
    logic [7:0]  e_idx, e_we, e_val;
    logic [31:0] e_data;

    task automatic model(input logic [127:0] w);
        logic [63:0] a, b, c, s1, s2;
        logic c0, c1, x;
        e_en = 0; e_ill = 0; e_idx = 0; e_data = 0; e_we = 0; e_val = 0;
        if ({w[91], w[11:0]} != 13'h210) begin
            e_ill = 1;
        end else if (prd(w[14:12]) ^ w[15]) begin
            x  = w[74];
            a  = {32'd0, md(rr(w[31:24]), w[72], x)};
            b  = {32'd0, md(rr(w[39:32]), w[63], x)};
            c  = {32'd0, md(rr(w[71:64]), w[75], x)};
            c0 = x & (prd(w[89:87]) ^ w[90]);
            c1 = x & (prd(w[79:77]) ^ w[80]);
            s1 = a + b + {63'd0, c0} + {63'd0, c1};
            s2 = {32'd0, s1[31:0]} + c;
            e_en = (w[23:16] != 8'd255);
            e_idx = w[23:16];
            e_data = s2[31:0];
            if (w[83:81] != 3'd0 && w[83:81] != 3'd7) begin
                e_we[w[83:81]] = 1'b1; e_val[w[83:81]] = (s1[63:32] != 0);
            end
            if (w[86:84] != 3'd0 && w[86:84] != 3'd7) begin
                e_we[w[86:84]] = 1'b1; e_val[w[86:84]] = s2[32];
            end
        end
    endtask

    task automatic check_out(input string tag);
        logic [57:0] got, exp;
        got = {wb_en, wb_en ? wb_idx : 8'd0, wb_en ? wb_data : 32'd0,
               pred_we, pred_we & pred_wval, illegal};
        exp = {e_en, e_en ? e_idx : 8'd0, e_en ? e_data : 32'd0,
               e_we, e_we & e_val, e_ill};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [127:0] w, input string tag);
        @(negedge clk);
        insn = w; insn_valid = 1'b1;
        model(w);
        @(negedge clk);
        insn_valid = 1'b0; insn = '0;
        check_out(tag);
        if (e_en) regs[e_idx] = e_data;
        for (int p = 0; p < 8; p++) if (e_we[p]) pm[p] = e_val[p];
    endtask

    task automatic idle_check(input string tag);
        e_en = 0; e_ill = 0; e_idx = 0; e_data = 0; e_we = 0; e_val = 0;
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] w;
        for (int i = 0; i < 256; i++) regs[i] = (32'h1357_9BDF * (i + 1)) ^ (i << 20);
        regs[1] = 32'd5; regs[2] = 32'd0; regs[3] = 32'hFFFF_FFFF; regs[4] = 32'd1;
        regs[255] = 32'hDEAD_BEEF;
        pm = 8'b0110_1001;   // raw bit 7 low, bit 0 high: constants must override
        repeat (3) @(negedge clk);
        // R8: reset state
        idle_check("R8 reset state");
        rst_n = 1'b1;
        idle_check("R8 idle after reset");

        for (int v = 0; v < NVEC; v++) begin
            run(mk(VT[v].ext, VT[v].ma, VT[v].mb, VT[v].mc, VT[v].ra, VT[v].rb, VT[v].rc,
                   VT[v].rd, VT[v].pu, VT[v].pv, VT[v].pp, VT[v].ppn, VT[v].pq, VT[v].pqn,
                   3'd7, 1'b0), "R9 table vector");
        end

        // R5: negate 5 -> 0xFFFFFFFB
        run(mk(0,1,0,0, 8'd1,8'd2,8'd2,8'd40, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd7,0), "R5 negate");
        checks++; if (regs[40] !== 32'hFFFF_FFFB) begin errors++;
            $display("FAIL R5 actual=%h expected=%h", regs[40], 32'hFFFF_FFFB); end
        // R6: complement 5 -> 0xFFFFFFFA, carry-ins false
        run(mk(1,1,0,0, 8'd1,8'd2,8'd2,8'd41, 3'd1,3'd2, 3'd0,0, 3'd0,0, 3'd7,0), "R6 complement");
        checks++; if (regs[41] !== 32'hFFFF_FFFA) begin errors++;
            $display("FAIL R6 actual=%h expected=%h", regs[41], 32'hFFFF_FFFA); end
        // R6 R3: carry-ins from idx 7 (true) and inverted idx 0 (true): 5+0+0+2
        run(mk(1,0,0,0, 8'd1,8'd2,8'd2,8'd42, 3'd1,3'd2, 3'd7,0, 3'd0,1, 3'd7,0), "R6 carry-ins");
        checks++; if (regs[42] !== 32'd7) begin errors++;
            $display("FAIL R6 actual=%h expected=%h", regs[42], 32'd7); end
        // R5: carry-ins ignored outside extended mode
        run(mk(0,0,0,0, 8'd1,8'd2,8'd2,8'd43, 3'd1,3'd2, 3'd7,0, 3'd0,1, 3'd7,0), "R5 no carry-in");
        // R7: first stage carries, second does not
        run(mk(0,0,0,0, 8'd3,8'd4,8'd3,8'd44, 3'd2,3'd3, 3'd7,0, 3'd7,0, 3'd7,0), "R7 first carry");
        // R7: second stage carries only
        run(mk(0,0,0,0, 8'd3,8'd2,8'd4,8'd45, 3'd2,3'd3, 3'd7,0, 3'd7,0, 3'd7,0), "R7 second carry");
        // R7: equal carry-out indices, second wins
        run(mk(0,0,0,0, 8'd3,8'd4,8'd2,8'd46, 3'd4,3'd4, 3'd7,0, 3'd7,0, 3'd7,0), "R7 same index");
        // R3: carry-outs aimed at constant predicates
        run(mk(0,0,0,0, 8'd3,8'd4,8'd3,8'd47, 3'd7,3'd0, 3'd7,0, 3'd7,0, 3'd7,0), "R3 const targets");
        // R3: predicate 0 reads false despite raw bit
        run(mk(1,0,0,0, 8'd1,8'd2,8'd2,8'd48, 3'd1,3'd2, 3'd0,0, 3'd0,0, 3'd7,0), "R3 pred0 false");
        // R4: destination 255 and source 255
        run(mk(0,0,0,0, 8'd255,8'd1,8'd2,8'd255, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd7,0), "R4 dest 255");
        run(mk(0,0,0,0, 8'd255,8'd1,8'd255,8'd49, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd7,0), "R4 src 255");
        checks++; if (regs[49] !== 32'd5) begin errors++;
            $display("FAIL R4 actual=%h expected=%h", regs[49], 32'd5); end
        // R2: guard false via inverted 7, via 0, and via a set predicate inverted
        run(mk(0,0,0,0, 8'd1,8'd1,8'd1,8'd50, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd7,1), "R2 guard !P7");
        run(mk(0,0,0,0, 8'd1,8'd1,8'd1,8'd50, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd0,0), "R2 guard P0");
        pm[3] = 1'b1;
        run(mk(0,0,0,0, 8'd1,8'd1,8'd1,8'd50, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd3,1), "R2 guard !P3");
        run(mk(0,0,0,0, 8'd1,8'd1,8'd1,8'd50, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd3,0), "R2 guard P3");
        // R1: wrong opcode high bit, wrong low bits
        w = mk(0,0,0,0, 8'd1,8'd1,8'd1,8'd51, 3'd1,3'd2, 3'd7,0, 3'd7,0, 3'd7,0);
        w[91] = 1'b1;
        run(w, "R1 opcode bit 91");
        w[91] = 1'b0; w[11:0] = 12'h211;
        run(w, "R1 opcode low bits");
        // R8: one-cycle pulse then idle
        idle_check("R8 pulse ends");

        for (int k = 0; k < 60; k++) begin
            w = mk($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                   8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                   3'($urandom), 3'($urandom), 3'($urandom), $urandom_range(0,1),
                   3'($urandom), $urandom_range(0,1), 3'($urandom), $urandom_range(0,1));
            run(w, "R9 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule